// File: doc/BRIEF.md
# Flash Access Channel Tunnel

This block carries flash requests from a device at the far end of a serial link to the host's flash controller. The device presents one request at a time: an operation code, a linear byte address, a length and, for writes, a data word. Before the request goes anywhere, the block checks two things. The whole byte span must lie below a programmable flash top. The operation must be allowed where that span sits.

The device always holds read, write and erase rights inside its own dedicated window. Elsewhere it may use only the regions of a small table of base/limit windows, and only for the operations whose permission bits are set. A request that passes goes to the flash controller port. A request that fails is never forwarded and is answered at once with an unsuccessful completion.

When the controller reports back, a completion is built toward the device as a separate transfer. It carries a status and, for a good read, the returned data word. New requests are held off until that completion has been taken.

Top module: `fchan_bridge`

## Requirements
- R1: Operation codes are 2'b00 read, 2'b01 write and 2'b10 erase. Code 2'b11 gets completion status 2'b01 (unsuccessful) and is never forwarded.
- R2: A forwarded request carries the latched operation code, address and length unchanged. The data word is forwarded only for a write and is zero for read and erase.
- R3: The last byte of a request is address + length, where the length field holds the byte count minus one. This sum is computed without wrapping. If it exceeds `flash_last_i`, the request is rejected.
- R4: Read, write and erase are all allowed when the whole span lies inside the dedicated window [`own_base_i`, `own_limit_i`].
- R5: Table region i covers [base_i, limit_i] and has three permission bits: bit 0 read, bit 1 write, bit 2 erase. An operation is allowed in the region only when its bit is set.
- R6: A span that is not wholly inside a single window is rejected as a whole, even if every window it touches would allow the operation.
- R7: A rejected request never appears on the flash controller port. It is answered with completion status 2'b01.
- R8: A forwarded request is completed only after `fc_done_i`. The status is 2'b00 (success) when `fc_err_i` is low and 2'b10 (controller error) when it is high.
- R9: `cpl_has_data_o` is 1 only on a successful read, and then `cpl_rdata_o` equals the controller's data. In every other case the flag is 0 and the data is zero.
- R10: After reset `req_ready_o` is 1 and both valid outputs are 0. Once a request is accepted, `req_ready_o` stays 0 until its completion has been taken.
- R11: `fc_valid_o` and `cpl_valid_o` stay high with stable contents until the matching ready input is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flash_last_i | input | ADDR_W | Highest valid flash byte address |
| own_base_i | input | ADDR_W | Dedicated window base |
| own_limit_i | input | ADDR_W | Dedicated window last byte |
| reg_base_i | input | NREG*ADDR_W | Region bases, region i at bits [i*ADDR_W +: ADDR_W] |
| reg_limit_i | input | NREG*ADDR_W | Region last bytes, same packing |
| reg_perm_i | input | NREG*3 | Region permissions, region i at [3i +: 3] |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_type_i | input | 2 | Operation code |
| req_addr_i | input | ADDR_W | Start byte address |
| req_len_i | input | LEN_W | Byte count minus one |
| req_wdata_i | input | DATA_W | Write data |
| fc_valid_o | output | 1 | Request to flash controller |
| fc_ready_i | input | 1 | Controller takes request |
| fc_type_o | output | 2 | Operation code |
| fc_addr_o | output | ADDR_W | Start address |
| fc_len_o | output | LEN_W | Byte count minus one |
| fc_wdata_o | output | DATA_W | Write data, zero unless write |
| fc_done_i | input | 1 | Controller finished, one-cycle pulse |
| fc_err_i | input | 1 | Controller error, valid with done |
| fc_rdata_i | input | DATA_W | Read data, valid with done |
| cpl_valid_o | output | 1 | Completion present |
| cpl_ready_i | input | 1 | Device takes completion |
| cpl_status_o | output | 2 | 00 success, 01 unsuccessful, 10 controller error |
| cpl_has_data_o | output | 1 | Read data attached |
| cpl_rdata_o | output | DATA_W | Read data |

## Verification
The bench builds the block with a 16-bit address, an 8-bit length, a 32-bit data word and four table regions. It sets the flash top at 0xEFFF. With this setup one region straddles the flash top, one region can only read and one can only erase. Two adjacent regions have different rights, and the top address 0xFFFF sits one byte below the wrap point. These choices bring span-crossing, out-of-range, unlisted-address and wrap cases within reach of short requests. The controller model stalls its ready signal and returns errors on demand. The device side stalls completion ready, so the hold-until-taken behaviour of both ports is exercised.

// File: rtl/fchan_pkg.sv
package fchan_pkg;
  typedef enum logic [1:0] {
    CYC_READ  = 2'b00,
    CYC_WRITE = 2'b01,
    CYC_ERASE = 2'b10,
    CYC_BAD   = 2'b11
  } cyc_e;

  typedef enum logic [1:0] {
    CPL_OK       = 2'b00,
    CPL_UNSUCC   = 2'b01,
    CPL_CTRL_ERR = 2'b10
  } cpl_st_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_ISSUE,
    S_WAIT,
    S_CPL
  } seq_st_e;
endpackage

// File: rtl/fchan_region_chk.sv
module fchan_region_chk #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 8,
  parameter int NREG   = 4
) (
  input  logic [1:0]             typ_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [ADDR_W-1:0]      flash_last_i,
  input  logic [ADDR_W-1:0]      own_base_i,
  input  logic [ADDR_W-1:0]      own_limit_i,
  input  logic [NREG*ADDR_W-1:0] reg_base_i,
  input  logic [NREG*ADDR_W-1:0] reg_limit_i,
  input  logic [NREG*3-1:0]      reg_perm_i,
  output logic                   ok_o
);
  localparam int EW = ADDR_W + 1;

  logic [EW-1:0]   end_w;
  logic            in_flash;
  logic            own_hit;
  logic [NREG-1:0] reg_hit;

  // widened sum: a span running past the top address cannot wrap
  assign end_w    = {1'b0, addr_i} + EW'(len_i);
  assign in_flash = end_w <= {1'b0, flash_last_i};
  assign own_hit  = (addr_i >= own_base_i) && (end_w <= {1'b0, own_limit_i});

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [ADDR_W-1:0] base, lim;
    logic [2:0]        perm;
    logic              allow;
    assign base = reg_base_i[i*ADDR_W +: ADDR_W];
    assign lim  = reg_limit_i[i*ADDR_W +: ADDR_W];
    assign perm = reg_perm_i[i*3 +: 3];
    always_comb begin
      case (typ_i)
        2'b00:   allow = perm[0];
        2'b01:   allow = perm[1];
        2'b10:   allow = perm[2];
        default: allow = 1'b0;
      endcase
    end
    assign reg_hit[i] = allow && (addr_i >= base) && (end_w <= {1'b0, lim});
  end

  assign ok_o = (typ_i != 2'b11) && in_flash && (own_hit || (|reg_hit));
endmodule

// File: rtl/fchan_seq.sv
module fchan_seq
  import fchan_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_type_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [1:0]        lat_type_o,
  output logic [ADDR_W-1:0] lat_addr_o,
  output logic [LEN_W-1:0]  lat_len_o,
  input  logic              chk_ok_i,
  output logic              fc_valid_o,
  input  logic              fc_ready_i,
  output logic [DATA_W-1:0] fc_wdata_o,
  input  logic              fc_done_i,
  input  logic              fc_err_i,
  input  logic [DATA_W-1:0] fc_rdata_i,
  output logic              cpl_valid_o,
  input  logic              cpl_ready_i,
  output logic [1:0]        cpl_status_o,
  output logic              cpl_has_data_o,
  output logic [DATA_W-1:0] cpl_rdata_o
);
  seq_st_e           st_q;
  logic [1:0]        typ_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] wdata_q;
  cpl_st_e           cst_q;
  logic              has_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rd_good;

  assign req_ready_o    = st_q == S_IDLE;
  assign fc_valid_o     = st_q == S_ISSUE;
  assign cpl_valid_o    = st_q == S_CPL;
  assign lat_type_o     = typ_q;
  assign lat_addr_o     = addr_q;
  assign lat_len_o      = len_q;
  assign fc_wdata_o     = wdata_q;
  assign cpl_status_o   = cst_q;
  assign cpl_has_data_o = has_q;
  assign cpl_rdata_o    = rdata_q;
  assign rd_good        = !fc_err_i && (typ_q == CYC_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      typ_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      wdata_q <= '0;
      cst_q   <= CPL_OK;
      has_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid_i) begin
          typ_q   <= req_type_i;
          addr_q  <= req_addr_i;
          len_q   <= req_len_i;
          wdata_q <= (req_type_i == CYC_WRITE) ? req_wdata_i : '0;
          st_q    <= S_CHECK;
        end
        S_CHECK: begin
          if (chk_ok_i) begin
            st_q <= S_ISSUE;
          end else begin
            cst_q   <= CPL_UNSUCC;
            has_q   <= 1'b0;
            rdata_q <= '0;
            st_q    <= S_CPL;
          end
        end
        S_ISSUE: if (fc_ready_i) st_q <= S_WAIT;
        S_WAIT: if (fc_done_i) begin
          cst_q   <= fc_err_i ? CPL_CTRL_ERR : CPL_OK;
          has_q   <= rd_good;
          rdata_q <= rd_good ? fc_rdata_i : '0;
          st_q    <= S_CPL;
        end
        S_CPL: if (cpl_ready_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r10_one_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
  a_r11_fc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fc_valid_o && !fc_ready_i |=> fc_valid_o && $stable(lat_addr_o) && $stable(lat_type_o)
      && $stable(fc_wdata_o));
  a_r11_cpl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o && !cpl_ready_i |=> cpl_valid_o && $stable(cpl_status_o) && $stable(cpl_rdata_o));
  a_r7_fwd_only_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fc_valid_o |-> chk_ok_i);
  a_r1_no_bad_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fc_valid_o |-> lat_type_o != 2'b11);
  a_r9_data_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o && cpl_has_data_o |-> cpl_status_o == CPL_OK && lat_type_o == CYC_READ);
  a_r8_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpl_valid_o) && cpl_status_o != CPL_UNSUCC |-> $past(fc_done_i));
endmodule

// File: rtl/fchan_bridge.sv
module fchan_bridge #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32,
  parameter int NREG   = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      flash_last_i,
  input  logic [ADDR_W-1:0]      own_base_i,
  input  logic [ADDR_W-1:0]      own_limit_i,
  input  logic [NREG*ADDR_W-1:0] reg_base_i,
  input  logic [NREG*ADDR_W-1:0] reg_limit_i,
  input  logic [NREG*3-1:0]      reg_perm_i,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [1:0]             req_type_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [LEN_W-1:0]       req_len_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  output logic                   fc_valid_o,
  input  logic                   fc_ready_i,
  output logic [1:0]             fc_type_o,
  output logic [ADDR_W-1:0]      fc_addr_o,
  output logic [LEN_W-1:0]       fc_len_o,
  output logic [DATA_W-1:0]      fc_wdata_o,
  input  logic                   fc_done_i,
  input  logic                   fc_err_i,
  input  logic [DATA_W-1:0]      fc_rdata_i,
  output logic                   cpl_valid_o,
  input  logic                   cpl_ready_i,
  output logic [1:0]             cpl_status_o,
  output logic                   cpl_has_data_o,
  output logic [DATA_W-1:0]      cpl_rdata_o
);
  logic [1:0]        lat_type;
  logic [ADDR_W-1:0] lat_addr;
  logic [LEN_W-1:0]  lat_len;
  logic              chk_ok;

  fchan_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_type_i, .req_addr_i, .req_len_i, .req_wdata_i,
    .lat_type_o(lat_type), .lat_addr_o(lat_addr), .lat_len_o(lat_len),
    .chk_ok_i(chk_ok),
    .fc_valid_o, .fc_ready_i, .fc_wdata_o, .fc_done_i, .fc_err_i, .fc_rdata_i,
    .cpl_valid_o, .cpl_ready_i, .cpl_status_o, .cpl_has_data_o, .cpl_rdata_o
  );

  fchan_region_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NREG(NREG)) u_chk (
    .typ_i(lat_type), .addr_i(lat_addr), .len_i(lat_len),
    .flash_last_i, .own_base_i, .own_limit_i,
    .reg_base_i, .reg_limit_i, .reg_perm_i,
    .ok_o(chk_ok)
  );

  assign fc_type_o = lat_type;
  assign fc_addr_o = lat_addr;
  assign fc_len_o  = lat_len;
endmodule

// File: tb/fchan_bridge_tb_top.sv
module fchan_bridge_tb_top;
  localparam int AW = 16, LW = 8, DW = 32, NR = 4;
  localparam logic [AW-1:0]    FLAST  = 16'hEFFF;
  localparam logic [AW-1:0]    OWN_B  = 16'h0000;
  localparam logic [AW-1:0]    OWN_L  = 16'h0FFF;
  localparam logic [NR*AW-1:0] RBASE  = {16'hE000, 16'h3000, 16'h2000, 16'h1000};
  localparam logic [NR*AW-1:0] RLIM   = {16'hFFFF, 16'h3FFF, 16'h2FFF, 16'h1FFF};
  localparam logic [NR*3-1:0]  RPERM  = {3'b111, 3'b100, 3'b011, 3'b001};

  typedef struct packed {
    logic [1:0] typ; logic [AW-1:0] addr; logic [LW-1:0] len; logic [DW-1:0] wdata;
  } fwd_t;
  typedef struct packed {
    logic [1:0] st; logic has; logic [DW-1:0] rdata;
  } cpl_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_type = 0;
  logic [AW-1:0] req_addr = 0;
  logic [LW-1:0] req_len = 0;
  logic [DW-1:0] req_wdata = 0;
  logic fc_valid, fc_ready = 0, fc_done = 0, fc_err = 0;
  logic [1:0] fc_type;
  logic [AW-1:0] fc_addr;
  logic [LW-1:0] fc_len;
  logic [DW-1:0] fc_wdata, fc_rdata = 0;
  logic cpl_valid, cpl_ready = 0, cpl_has;
  logic [1:0] cpl_st;
  logic [DW-1:0] cpl_rdata;

  int checks = 0, errors = 0, cyc = 0, fwd_exp = 0, fwd_seen = 0;
  bit inj_err = 0, done_flag = 0;
  fwd_t fq[$];
  cpl_t cq[$];

  always #5 clk = ~clk;

  fchan_bridge #(.ADDR_W(AW), .LEN_W(LW), .DATA_W(DW), .NREG(NR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flash_last_i(FLAST), .own_base_i(OWN_B), .own_limit_i(OWN_L),
    .reg_base_i(RBASE), .reg_limit_i(RLIM), .reg_perm_i(RPERM),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_type_i(req_type),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_wdata_i(req_wdata),
    .fc_valid_o(fc_valid), .fc_ready_i(fc_ready), .fc_type_o(fc_type), .fc_addr_o(fc_addr),
    .fc_len_o(fc_len), .fc_wdata_o(fc_wdata), .fc_done_i(fc_done), .fc_err_i(fc_err),
    .fc_rdata_i(fc_rdata), .cpl_valid_o(cpl_valid), .cpl_ready_i(cpl_ready),
    .cpl_status_o(cpl_st), .cpl_has_data_o(cpl_has), .cpl_rdata_o(cpl_rdata)
  );

  task automatic chk(bit c, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit exp_ok(logic [1:0] t, logic [AW-1:0] a, logic [LW-1:0] l);
    logic [AW:0] e;
    e = {1'b0, a} + (AW+1)'(l);
    if (t == 2'b11) return 0;                       // R1
    if (e > {1'b0, FLAST}) return 0;                // R3
    if (a >= OWN_B && e <= {1'b0, OWN_L}) return 1; // R4
    for (int i = 0; i < NR; i++)                    // R5, R6: one window holds whole span
      if (a >= RBASE[i*AW +: AW] && e <= {1'b0, RLIM[i*AW +: AW]} && RPERM[i*3 + int'(t)])
        return 1;
    return 0;
  endfunction

  // driver: pushes expectations, then presents the request
  task automatic send(logic [1:0] t, logic [AW-1:0] a, logic [LW-1:0] l, logic [DW-1:0] w, bit err);
    bit ok;
    cpl_t c;
    fwd_t f;
    ok = exp_ok(t, a, l);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    inj_err = err;
    if (ok) begin
      f.typ = t; f.addr = a; f.len = l; f.wdata = (t == 2'b01) ? w : '0;  // R2
      fq.push_back(f);
      fwd_exp++;
      c.st = err ? 2'b10 : 2'b00;                                          // R8
      c.has = !err && t == 2'b00;                                          // R9
      c.rdata = c.has ? {16'hC0DE, a} : '0;
    end else begin
      c.st = 2'b01; c.has = 0; c.rdata = '0;                               // R7
    end
    cq.push_back(c);
    req_valid = 1; req_type = t; req_addr = a; req_len = l; req_wdata = w;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R10 ready low after accept", 64'(req_ready), 64'd0);
  endtask

  // flash controller model
  int pend = 0;
  logic [DW-1:0] pend_rd;
  always @(negedge clk) begin
    fwd_t f;
    cyc++;
    fc_done = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin fc_done = 1; fc_err = inj_err; fc_rdata = pend_rd; end
    end
    fc_ready = (cyc % 3) != 0;
    if (rst_n && fc_valid && fc_ready) begin
      fwd_seen++;
      if (fq.size() == 0) begin
        chk(0, "R7 unexpected forward", 64'(fc_addr), 64'd0);
      end else begin
        f = fq.pop_front();
        chk(fc_type == f.typ && fc_addr == f.addr && fc_len == f.len, "R2 fields",
            {fc_type, fc_addr, fc_len}, {f.typ, f.addr, f.len});
        chk(fc_wdata == f.wdata, "R2 payload", 64'(fc_wdata), 64'(f.wdata));
      end
      pend = 2;
      pend_rd = {16'hC0DE, fc_addr};
    end
  end

  // completion monitor / scoreboard
  bit hold_prev = 0;
  cpl_t hold_v;
  always @(negedge clk) begin
    cpl_t e;
    if (hold_prev)
      chk(cpl_valid && cpl_st == hold_v.st && cpl_rdata == hold_v.rdata, "R11 cpl hold",
          {cpl_valid, cpl_st, cpl_rdata}, {1'b1, hold_v.st, hold_v.rdata});
    cpl_ready = (cyc % 4) != 1;
    hold_prev = rst_n && cpl_valid && !cpl_ready;
    hold_v.st = cpl_st; hold_v.has = cpl_has; hold_v.rdata = cpl_rdata;
    if (rst_n && cpl_valid && cpl_ready) begin
      if (cq.size() == 0) begin
        chk(0, "R7 unexpected completion", 64'(cpl_st), 64'd0);
      end else begin
        e = cq.pop_front();
        chk(cpl_st == e.st, "R8 status", 64'(cpl_st), 64'(e.st));
        chk(cpl_has == e.has && cpl_rdata == e.rdata, "R9 data",
            {cpl_has, cpl_rdata}, {e.has, e.rdata});
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) if (cyc > 20000) begin
    chk(0, "watchdog", 64'(cyc), 64'd0);
    finish_run();
  end

  initial begin
    #1;
    chk(req_ready == 1 && fc_valid == 0 && cpl_valid == 0, "R10 reset state",
        {req_ready, fc_valid, cpl_valid}, 3'b100);
    repeat (3) @(negedge clk);
    rst_n = 1;
    send(2'b00, 16'h0010, 8'h03, 32'h0, 0);          // R4 read own, R9 data
    send(2'b01, 16'h0100, 8'h07, 32'hDEADBEEF, 0);   // R4 write, R2 payload
    send(2'b10, 16'h0800, 8'hFF, 32'h12345678, 0);   // R4 erase, R2 payload zeroed
    send(2'b00, 16'h1200, 8'h0F, 32'h0, 0);          // R5 read-only region
    send(2'b01, 16'h1200, 8'h0F, 32'h1, 0);          // R5 write denied
    send(2'b10, 16'h3000, 8'h10, 32'h0, 0);          // R5 erase-only region
    send(2'b00, 16'h3000, 8'h01, 32'h0, 0);          // R5 read denied
    send(2'b01, 16'h2FFE, 8'h03, 32'h5, 0);          // R6 span crosses regions
    send(2'b00, 16'h0FFE, 8'h03, 32'h0, 0);          // R6 own/region span, both readable
    send(2'b00, 16'h5000, 8'h00, 32'h0, 0);          // R7 unlisted address
    send(2'b00, 16'hEFF0, 8'h0F, 32'h0, 0);          // R3 ends exactly at top
    send(2'b00, 16'hEFF0, 8'h10, 32'h0, 0);          // R3 one past top
    send(2'b10, 16'hFFFF, 8'h01, 32'h0, 0);          // R3 no wrap
    send(2'b11, 16'h0020, 8'h00, 32'h0, 0);          // R1 illegal code
    send(2'b00, 16'h0040, 8'h07, 32'h0, 1);          // R8 controller error on read
    send(2'b01, 16'h2100, 8'h03, 32'hA5A5A5A5, 1);   // R8 controller error on write
    send(2'b01, 16'h2100, 8'h03, 32'h0BADF00D, 0);   // R5 write region
    while (cq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(fwd_seen == fwd_exp, "R7 forward count", 64'(fwd_seen), 64'(fwd_exp));
    chk(req_ready == 1 && fc_valid == 0 && cpl_valid == 0, "R10 idle at end",
        {req_ready, fc_valid, cpl_valid}, 3'b100);
    finish_run();
  end
endmodule